// File: doc/BRIEF.md
# Cyclic Wake Sensing Sequencer

This block supervises two wake inputs while the system sits in one of its low-power modes. When cyclic sensing is enabled, it powers an external sense switch for one slow tick out of every 128. It samples the wake inputs as that window closes, and it raises a wake event when the inputs move away from a stored reference level. The reference is taken as two consecutive samples when a low-power session starts. If those two samples disagree while entering sleep with cyclic sensing, the block raises an initialization-fail flag. The mode logic outside the block uses that flag as a request to fall back to battery standby.

The block is clocked by the system clock and advances its schedule on a single-cycle `tick` strobe, which is about 0.5 ms apart. Without cyclic sensing, the wake inputs are sampled on every tick. In the active modes, and in standby without cyclic sensing, the switch simply follows a control bit. An overcurrent on the switch in standby, or in sleep with cyclic sensing, is also reported as a wake.

There is no data stream here, so there is no valid/ready handshake. All pins are plain control and status levels. The wake event and its captured levels stay latched until software clears them or the system returns to an active mode.

Top module: `cyc_wake_seq`

## Requirements
- R1: Mode encoding is 00 sleep, 01 battery standby, 10 receive-only, 11 normal. In modes 10 and 11, `sw_drv` equals `sw_ctl`. In standby without cyclic sensing, `sw_drv` equals `sw_ctl`. In sleep without cyclic sensing, `sw_drv` is 0.
- R2: In sleep or standby with `cyc_en`=1, `sw_drv` is high from session entry until the first tick. After that it is high for exactly one tick interval out of every 128 ticks. It turns on at the tick that ends interval 127 and turns off at the following tick.
- R3: While `rst_n` is low or `wd_rst` is high, `sw_drv` is 0 in the same cycle. A clock edge with `wd_rst` high clears `wake_evt` and `init_fail`.
- R4: A low-power session starts on any entry into mode 00 or 01, and on any change of mode or of `cyc_en` while in those modes. At the start, the first two samples set the reference. If the two samples differ while in sleep with `cyc_en`=1, `init_fail` goes high after the second sample and no wake is raised. In any other case a mismatch does not set `init_fail`.
- R5: After the reference is set, a wake is raised only when two consecutive samples are equal to each other and differ from the reference. The change may be in either direction on either input. A deviation that lasts for a single sample raises no wake.
- R6: With `cyc_en`=1, samples are taken only at the tick that closes a switch-on window. With `cyc_en`=0, a sample is taken at every tick.
- R7: `ovc` high in standby, or in sleep with `cyc_en`=1, raises a wake in the following cycle. `ovc` in sleep without cyclic sensing is ignored.
- R8: While `wake_evt` is high, `wake_lvl` holds the input levels that caused the wake. Otherwise `wake_lvl` equals `wk_in`.
- R9: `wake_clr` high clears `wake_evt` and `init_fail` at the next edge, and no new wake is raised while it stays high. After a clear, the captured levels become the new reference.
- R10: A clock edge in mode 10 or 11 clears `wake_evt` and `init_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wd_rst | input | 1 | Watchdog reset, synchronous, active high |
| tick | input | 1 | Single-cycle slow cycle strobe |
| mode | input | 2 | Operating mode (00 sleep, 01 standby, 10 receive-only, 11 normal) |
| cyc_en | input | 1 | Cyclic sensing enable |
| sw_ctl | input | 1 | Direct switch-on control bit |
| wk_in | input | 2 | Synchronized wake input levels |
| ovc | input | 1 | Switch overcurrent flag |
| wake_clr | input | 1 | Clear for the wake latch and the fail flag |
| sw_drv | output | 1 | Sense switch drive |
| wake_evt | output | 1 | Latched wake event |
| init_fail | output | 1 | Reference initialization mismatch flag |
| wake_lvl | output | 2 | Captured wake levels, or live levels when no wake is latched |

## Verification
A wrong phase count shows at once in `sw_drv`: the switch-on window turns up one or more ticks early or late, within a single 128-tick period. A fault in the reference or the filter state shows in `wake_evt` within two samples of an input change. In the failing cases, the wake is raised after only one sample, raised on a level that matches the reference, or never raised at all. A wrong captured value shows in `wake_lvl` as soon as the wake latches. A wrong initialization state shows as `init_fail` missing or spurious at the second sample of a cyclic sleep entry.

// File: rtl/cws_pkg.sv
package cws_pkg;
  typedef enum logic [1:0] {
    M_SLEEP = 2'b00,
    M_STBY  = 2'b01,
    M_RXO   = 2'b10,
    M_NORM  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_REF0 = 2'b00,
    S_REF1 = 2'b01,
    S_RUN  = 2'b10
  } seq_e;
endpackage

// File: rtl/cws_phase.sv
module cws_phase #(
  parameter int PERIOD = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_rst,
  input  logic tick,
  input  logic lp,
  input  logic cyc,
  input  logic restart,
  output logic smp,
  output logic win_on
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] phase_q;
  logic          at_zero;

  assign at_zero = (phase_q == '0);
  assign win_on  = restart | at_zero;
  assign smp     = tick & lp & ~restart & ~wd_rst & (~cyc | at_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (wd_rst || restart || !lp || !cyc) begin
      phase_q <= '0;
    end else if (tick) begin
      if (phase_q == PW'(PERIOD - 1)) phase_q <= '0;
      else                            phase_q <= phase_q + 1'b1;
    end
  end

  // R2
  win_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lp && cyc && !restart && !wd_rst && at_zero) |=> (!win_on || restart));
endmodule

// File: rtl/cws_wake.sv
module cws_wake #(
  parameter int NW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_rst,
  input  logic          lp,
  input  logic          restart,
  input  logic          fail_arm,
  input  logic          ovc_hit,
  input  logic          smp,
  input  logic [NW-1:0] wk,
  input  logic          clr,
  output logic          wake,
  output logic          fail,
  output logic [NW-1:0] diag
);
  import cws_pkg::*;

  seq_e          st;
  logic [NW-1:0] ref_q, prev_q, cap_q;
  logic          prev_v, wake_q, fail_q;
  logic          differs;

  assign differs = (wk != ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_REF0; ref_q <= '0; prev_q <= '0; cap_q <= '0;
      prev_v <= 1'b0; wake_q <= 1'b0; fail_q <= 1'b0;
    end else if (wd_rst) begin
      st <= S_REF0; prev_v <= 1'b0; wake_q <= 1'b0; fail_q <= 1'b0;
    end else if (!lp) begin
      st <= S_REF0; prev_v <= 1'b0; wake_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      if (restart) begin
        st     <= S_REF0;
        prev_v <= 1'b0;
      end else if (smp) begin
        case (st)
          S_REF0: begin
            ref_q <= wk;
            st    <= S_REF1;
          end
          S_REF1: begin
            if (differs && fail_arm) fail_q <= 1'b1;
            ref_q  <= wk;
            prev_v <= 1'b0;
            st     <= S_RUN;
          end
          S_RUN: begin
            if (!wake_q && !clr) begin
              if (differs && prev_v && (wk == prev_q)) begin
                wake_q <= 1'b1;
                cap_q  <= wk;
              end
              prev_q <= wk;
              prev_v <= differs;
            end
          end
          default: st <= S_REF0;
        endcase
      end
      if (ovc_hit && !wake_q && !clr) begin
        wake_q <= 1'b1;
        cap_q  <= wk;
      end
      if (clr) begin
        wake_q <= 1'b0;
        fail_q <= 1'b0;
        prev_v <= 1'b0;
        if (wake_q) ref_q <= cap_q;
      end
    end
  end

  assign wake = wake_q;
  assign fail = fail_q;
  assign diag = wake_q ? cap_q : wk;

  // R8
  diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && !clr && lp && !wd_rst) |=> (wake_q && $stable(diag)));

  // R10
  active_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lp |=> (!wake_q && !fail_q));

  // R9
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wake_q);

  // R4
  fail_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(fail_arm && smp));
endmodule

// File: rtl/cws_drive.sv
module cws_drive (
  input  logic       rst_n,
  input  logic       wd_rst,
  input  logic [1:0] mode,
  input  logic       ctl,
  input  logic       cyc,
  input  logic       win_on,
  output logic       sw
);
  import cws_pkg::*;

  always_comb begin
    sw = 1'b0;
    if (rst_n && !wd_rst) begin
      if (mode[1])              sw = ctl;
      else if (cyc)             sw = win_on;
      else if (mode == M_STBY)  sw = ctl;
    end
  end
endmodule

// File: rtl/cyc_wake_seq.sv
module cyc_wake_seq #(
  parameter int PERIOD = 128,
  parameter int NW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_rst,
  input  logic          tick,
  input  logic [1:0]    mode,
  input  logic          cyc_en,
  input  logic          sw_ctl,
  input  logic [NW-1:0] wk_in,
  input  logic          ovc,
  input  logic          wake_clr,
  output logic          sw_drv,
  output logic          wake_evt,
  output logic          init_fail,
  output logic [NW-1:0] wake_lvl
);
  import cws_pkg::*;

  logic [1:0] mode_q;
  logic       cyc_q;
  logic       lp, restart, smp, win_on, fail_arm, ovc_hit;

  assign lp       = ~mode[1];
  assign restart  = lp & ((mode != mode_q) | (cyc_en != cyc_q));
  assign fail_arm = (mode == M_SLEEP) & cyc_en;
  assign ovc_hit  = lp & ovc & (cyc_en | (mode == M_STBY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_NORM;
      cyc_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      cyc_q  <= cyc_en;
    end
  end

  cws_phase #(.PERIOD(PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst), .tick(tick), .lp(lp),
    .cyc(cyc_en), .restart(restart), .smp(smp), .win_on(win_on)
  );

  cws_wake #(.NW(NW)) u_wake (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst), .lp(lp), .restart(restart),
    .fail_arm(fail_arm), .ovc_hit(ovc_hit), .smp(smp), .wk(wk_in),
    .clr(wake_clr), .wake(wake_evt), .fail(init_fail), .diag(wake_lvl)
  );

  cws_drive u_drive (
    .rst_n(rst_n), .wd_rst(wd_rst), .mode(mode), .ctl(sw_ctl),
    .cyc(cyc_en), .win_on(win_on), .sw(sw_drv)
  );

  // R3
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> (!wake_evt && !init_fail));

  // R7
  ovc_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_hit && !wake_clr && !wd_rst) |=> wake_evt);
endmodule

// File: tb/cyc_wake_seq_tb.sv
module cyc_wake_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n, wd_rst, tick, cyc_en, sw_ctl, ovc, wake_clr;
  logic [1:0] mode, wk_in;
  logic       sw_drv, wake_evt, init_fail;
  logic [1:0] wake_lvl;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  cyc_wake_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst), .tick(tick), .mode(mode),
    .cyc_en(cyc_en), .sw_ctl(sw_ctl), .wk_in(wk_in), .ovc(ovc),
    .wake_clr(wake_clr), .sw_drv(sw_drv), .wake_evt(wake_evt),
    .init_fail(init_fail), .wake_lvl(wake_lvl)
  );

  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick <= 1'b1;
      @(negedge clk);
      tick <= 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] m, input logic cy, input logic [1:0] w);
    mode = 2'b11;
    wait_ticks(1);
    wk_in  = w;
    cyc_en = cy;
    mode   = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wd_rst = 1'b0; mode = 2'b11; cyc_en = 1'b0;
    sw_ctl = 1'b1; wk_in = 2'b00; ovc = 1'b0; wake_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 sw off in reset", sw_drv, 0);
    chk("R3 wake clear in reset", wake_evt, 0);
    chk("R4 fail clear in reset", init_fail, 0);
    chk("R8 live levels after reset", wake_lvl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 normal follows ctl", sw_drv, 1);

    // R1 sweep over modes, control bit and cyclic enable
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int y = 0; y < 2; y++) begin
          if (m < 2 && y == 1) continue;
          mode = m[1:0]; sw_ctl = c[0]; cyc_en = y[0];
          @(negedge clk);
          @(negedge clk);
          chk($sformatf("R1 mode=%0d ctl=%0d cyc=%0d", m, c, y), sw_drv, (m == 0) ? 0 : c);
        end

    // R3 watchdog reset forces the switch off at once
    mode = 2'b11; sw_ctl = 1'b1; cyc_en = 1'b0;
    @(negedge clk);
    wd_rst = 1'b1;
    #1;
    chk("R3 wd_rst forces off", sw_drv, 0);
    @(negedge clk);
    wd_rst = 1'b0;
    #1;
    chk("R3 released", sw_drv, 1);
    sw_ctl = 1'b0;

    // R5 R8 exhaustive pairs in standby without cyclic sensing (R6 per-tick sampling)
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        if (a == b) continue;
        enter(2'b01, 1'b0, a[1:0]);
        wait_ticks(3);
        chk($sformatf("R8 live a=%0d", a), wake_lvl, a);
        wk_in = b[1:0];
        wait_ticks(1);
        chk($sformatf("R5 one sample a=%0d b=%0d", a, b), wake_evt, 0);
        wait_ticks(1);
        chk($sformatf("R6 R5 wake a=%0d b=%0d", a, b), wake_evt, 1);
        chk($sformatf("R8 captured a=%0d b=%0d", a, b), wake_lvl, b);
        wk_in = a[1:0];
        wait_ticks(2);
        chk($sformatf("R8 held a=%0d b=%0d", a, b), wake_lvl, b);
        // single-sample glitch
        enter(2'b01, 1'b0, a[1:0]);
        wait_ticks(3);
        wk_in = b[1:0];
        wait_ticks(1);
        wk_in = a[1:0];
        wait_ticks(3);
        chk($sformatf("R5 glitch a=%0d b=%0d", a, b), wake_evt, 0);
      end

    // R9 clear, blocking while held, new reference
    enter(2'b01, 1'b0, 2'b00);
    wait_ticks(3);
    wk_in = 2'b11;
    wait_ticks(2);
    chk("R9 pre wake", wake_evt, 1);
    wake_clr = 1'b1;
    @(negedge clk);
    chk("R9 cleared", wake_evt, 0);
    chk("R9 diag live", wake_lvl, 3);
    wk_in = 2'b01;
    wait_ticks(3);
    chk("R9 blocked while held", wake_evt, 0);
    wk_in = 2'b11;
    @(negedge clk);
    wake_clr = 1'b0;
    wait_ticks(3);
    chk("R9 new ref no wake", wake_evt, 0);
    wk_in = 2'b10;
    wait_ticks(2);
    chk("R9 wake after clear", wake_evt, 1);
    chk("R9 wake levels", wake_lvl, 2);

    // R10 active mode clears
    mode = 2'b10;
    @(negedge clk);
    chk("R10 active clears wake", wake_evt, 0);

    // R7 overcurrent
    enter(2'b01, 1'b0, 2'b00);
    wait_ticks(3);
    ovc = 1'b1;
    @(negedge clk);
    ovc = 1'b0;
    chk("R7 ovc standby wake", wake_evt, 1);
    enter(2'b00, 1'b0, 2'b00);
    wait_ticks(3);
    ovc = 1'b1;
    @(negedge clk);
    ovc = 1'b0;
    @(negedge clk);
    chk("R7 ovc ignored in plain sleep", wake_evt, 0);

    // R4 no fail flag without cyclic sensing
    enter(2'b00, 1'b0, 2'b00);
    wait_ticks(1);
    wk_in = 2'b01;
    wait_ticks(2);
    chk("R4 no fail without cyclic", init_fail, 0);
    chk("R4 no wake on init mismatch", wake_evt, 0);

    // R2 R4 R6 cyclic sleep session
    enter(2'b00, 1'b1, 2'b00);
    @(negedge clk);
    chk("R2 on at entry", sw_drv, 1);
    wait_ticks(1);
    chk("R2 off after first window", sw_drv, 0);
    wait_ticks(1);
    wk_in = 2'b01;
    wait_ticks(126);
    chk("R4 fail not before second sample", init_fail, 0);
    chk("R2 on at tick 128", sw_drv, 1);
    wait_ticks(1);
    chk("R4 fail after mismatch", init_fail, 1);
    chk("R4 no wake from mismatch", wake_evt, 0);
    chk("R2 off after window", sw_drv, 0);
    wait_ticks(126);
    chk("R2 off before period end", sw_drv, 0);
    wait_ticks(1);
    chk("R2 on after 128 ticks", sw_drv, 1);
    wait_ticks(1);
    chk("R2 on for one tick", sw_drv, 0);
    wk_in = 2'b00;
    wait_ticks(126);
    chk("R6 no sample between windows", wake_evt, 0);
    wait_ticks(2);
    chk("R5 first confirm only", wake_evt, 0);
    wait_ticks(128);
    chk("R6 wake at window", wake_evt, 1);
    chk("R8 cyclic captured", wake_lvl, 0);
    wake_clr = 1'b1;
    @(negedge clk);
    wake_clr = 1'b0;
    chk("R9 fail cleared", init_fail, 0);
    ovc = 1'b1;
    @(negedge clk);
    ovc = 1'b0;
    chk("R7 ovc cyclic sleep wake", wake_evt, 1);
    wd_rst = 1'b1;
    @(negedge clk);
    wd_rst = 1'b0;
    chk("R3 wd_rst clears wake", wake_evt, 0);

    finish_run();
  end
endmodule